// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block serialises a byte stream into a bit-synchronous HDLC line signal. It sends one line bit for each cycle in which the bit enable is high. Bytes arrive over a valid/ready handshake, and a marker on the last byte closes the frame. Between frames the line carries back-to-back flags. A frame always starts at the boundary after a flag. Its bytes (address, control and payload, in the order they arrive) go out least-significant bit first. After the final byte the block sends a 16-bit check sequence and then a closing flag. That flag also serves as the opening flag of any frame that follows at once.

Zero-bit insertion makes every frame transparent. A 0 is inserted after every fifth consecutive 1 of frame content, and this includes the check sequence. Flags and aborts are never stuffed. If the source has no byte ready in the middle of a frame, the block sends an abort pattern and then goes back to flags.

Top module: `hdlc_tx`

## Requirements
- R1: While `rst` is high, `line_bit` is 1 and `in_ready` is 0. The first bits after reset are a complete flag.
- R2: With no frame pending, the line repeats the flag byte 0x7E continuously. The bits on the line are 0,1,1,1,1,1,1,0.
- R3: `line_bit` changes only in the cycle after a clock edge at which `bit_en` was high. It holds its value otherwise.
- R4: A frame on the line is a flag, then the accepted bytes in order, each sent bit 0 first, then two check bytes, then a flag. Consecutive frames share a single flag.
- R5: After five consecutive content 1 bits, a 0 is inserted. Any emitted 0, including an inserted one, restarts the count. Flag and abort bits are never counted or stuffed. Any payload value, including 0x7E and 0xFF, therefore arrives intact.
- R6: The check sequence is computed over every content byte with generator x^16+x^12+x^5+1. It is processed bit 0 first, starts from 0xFFFF, and is sent ones-complemented, low byte first. For the payload "123456789" the check bytes are 0x6E then 0x90.
- R7: `in_ready` is high only in a cycle with `bit_en` high, when the last bit of a flag or of a non-final byte is being emitted. It is never high on an inserted zero or during an abort. A byte transfers when `in_valid` and `in_ready` are both high at a clock edge.
- R8: If `in_valid` is low when a mid-frame byte is needed, the block sends eight 1 bits (an abort) and then flags. It can then start a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit enable; one line bit per high cycle |
| in_data | input | BYTE_W | Byte to transmit |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte at this edge |
| line_bit | output | 1 | Serial line output |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a stuffing run of five and an eight-bit abort. These are the values for which a real HDLC receiver model can be written directly, and the bench decodes the line with such a model. It drives an irregular bit-enable pattern, which puts stuffing decisions, byte handovers and the frame-closing transition on cycles where the enable is low as well as high. Payloads made of 0xFF and 0x7E push runs of ones across byte edges and into the check bytes. A deliberate source starvation makes the abort path and the return to framing observable on the line.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;

    localparam int          CRC_W    = 16;
    localparam int          FLAG_W   = 8;
    localparam logic [7:0]  FLAG_PAT = 8'h7E;
    localparam logic [15:0] CRC_REV  = 16'h8408;   // reflected x^16+x^12+x^5+1
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_FLAG  = 2'd0,
        ST_DATA  = 2'd1,
        ST_CRC   = 2'd2,
        ST_ABORT = 2'd3
    } tx_state_e;

    function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] c,
                                                      input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_REV : '0);
    endfunction

endpackage

// File: rtl/hdlc_crc.sv
module hdlc_crc
    import hdlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;

    assign crc_next = crc_bit_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_INIT;
        else if (en)     crc_q <= crc_next;
    end
endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bit_val,
    input  logic counted,
    output logic stuff
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones_q;

    assign stuff = (ones_q == CW'(RUN));

    always_ff @(posedge clk) begin
        if (rst)                      ones_q <= '0;
        else if (tick) begin
            if (stuff)                ones_q <= '0;
            else if (counted && bit_val) ones_q <= ones_q + 1'b1;
            else                      ones_q <= '0;
        end
    end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 5,
    parameter int ABORT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              line_bit
);
    localparam int SH_W  = CRC_W;
    localparam int CNT_W = $clog2(SH_W);

    tx_state_e        state_q;
    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] left_q;
    logic             last_q;
    logic             line_q;

    logic             stuff;
    logic             shift_tick;
    logic             word_end;
    logic             content;
    logic             take;
    logic             aborting;
    logic [CRC_W-1:0] crc_next;

    assign content    = (state_q == ST_DATA) || (state_q == ST_CRC);
    assign aborting   = (state_q == ST_ABORT);
    assign shift_tick = bit_en && !stuff;
    assign word_end   = shift_tick && (left_q == '0);
    assign in_ready   = !rst && word_end &&
                        ((state_q == ST_FLAG) || (state_q == ST_DATA && !last_q));
    assign take       = in_ready && in_valid;
    assign line_bit   = line_q;

    hdlc_zero_ins #(.RUN(STUFF_RUN)) u_zins (
        .clk     (clk),
        .rst     (rst),
        .tick    (bit_en),
        .bit_val (sh_q[0]),
        .counted (content),
        .stuff   (stuff)
    );

    hdlc_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .init     (take && state_q == ST_FLAG),
        .en       (shift_tick && state_q == ST_DATA),
        .din      (sh_q[0]),
        .crc_next (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLAG;
            sh_q    <= SH_W'(FLAG_PAT);
            left_q  <= CNT_W'(FLAG_W - 1);
            last_q  <= 1'b0;
            line_q  <= 1'b1;
        end else begin
            if (bit_en) line_q <= stuff ? 1'b0 : sh_q[0];
            if (word_end) begin
                unique case (state_q)
                    ST_FLAG: begin
                        if (take) begin
                            state_q <= ST_DATA;
                            sh_q    <= SH_W'(in_data);
                            left_q  <= CNT_W'(BYTE_W - 1);
                            last_q  <= in_last;
                        end else begin
                            sh_q    <= SH_W'(FLAG_PAT);
                            left_q  <= CNT_W'(FLAG_W - 1);
                        end
                    end
                    ST_DATA: begin
                        if (last_q) begin
                            state_q <= ST_CRC;
                            sh_q    <= ~crc_next;
                            left_q  <= CNT_W'(CRC_W - 1);
                        end else if (take) begin
                            sh_q    <= SH_W'(in_data);
                            left_q  <= CNT_W'(BYTE_W - 1);
                            last_q  <= in_last;
                        end else begin
                            state_q <= ST_ABORT;
                            sh_q    <= '1;
                            left_q  <= CNT_W'(ABORT_LEN - 1);
                        end
                    end
                    default: begin
                        state_q <= ST_FLAG;
                        sh_q    <= SH_W'(FLAG_PAT);
                        left_q  <= CNT_W'(FLAG_W - 1);
                        last_q  <= 1'b0;
                    end
                endcase
            end else if (shift_tick) begin
                sh_q   <= sh_q >> 1;
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic line_bit,
    input logic in_ready,
    input logic aborting
);
    logic       new_q;
    logic       abort_d;
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            new_q   <= 1'b0;
            abort_d <= 1'b0;
            run_q   <= '0;
        end else begin
            new_q   <= bit_en;
            abort_d <= aborting;
            if (new_q) run_q <= line_bit ? ((run_q == 4'hF) ? run_q : run_q + 1'b1) : '0;
        end
    end

    AST_RUN_ONLY_IN_ABORT: assert property (@(posedge clk) disable iff (rst)
        (new_q && line_bit && run_q >= 4'd6) |-> abort_d);              // R5
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_en);                                           // R7
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_bit));                                 // R3
    AST_NO_READY_IN_ABORT: assert property (@(posedge clk) disable iff (rst)
        aborting |-> !in_ready);                                        // R8
endmodule

bind hdlc_tx hdlc_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .line_bit (line_bit),
    .in_ready (in_ready),
    .aborting (aborting)
);

// File: tb/sim_hdlc_tx.sv
`timescale 1ns/1ps
module sim_hdlc_tx;
    localparam int NTBL = 5;
    localparam logic [95:0] TBL_BYTES [NTBL] = '{
        96'h39_38_37_36_35_34_33_32_31,
        96'hFF_FF_FF_FF,
        96'h7E_7E_7E,
        96'h01,
        96'hF8_00_55_AA_03_FF
    };
    localparam int TBL_LEN [NTBL] = '{9, 4, 3, 1, 6};

    logic clk = 0, rst = 1, bit_en = 0;
    logic [7:0] in_data = 0;
    logic in_valid = 0, in_last = 0;
    logic in_ready, line_bit;

    always #5 clk = ~clk;

    hdlc_tx u0 (.clk(clk), .rst(rst), .bit_en(bit_en), .in_data(in_data),
                .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
                .line_bit(line_bit));

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // source queue
    logic [7:0] q_data [0:255];
    logic       q_last [0:255];
    int q_n = 0, q_i = 0;
    bit fire_pending = 0;
    int ready_viol = 0;

    // expected frames
    logic [7:0] exp_data [0:7][0:15];
    int exp_len [0:7];
    int exp_n = 0;

    task automatic push_frame(input logic [95:0] b, input int len, input bit close);
        for (int k = 0; k < len; k++) begin
            q_data[q_n] = b[8*k +: 8];
            q_last[q_n] = close && (k == len - 1);
            q_n++;
            if (close) exp_data[exp_n][k] = b[8*k +: 8];
        end
        if (close) begin
            exp_len[exp_n] = len;
            exp_n++;
        end
    endtask

    function automatic logic [15:0] ref_fcs(input int f, input int len);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < len; k++)
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ exp_data[f][k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return ~c;
    endfunction

    // line decoder
    bit   dec_hunt = 1;
    int   dec_run = 0, dec_nb = 0, abort_cnt = 0, fcount = 0, raw_cnt = 0;
    logic [7:0] dec_last8 = 0;
    logic dec_bits [0:1023];
    logic raw_idle [0:23];

    task automatic end_frame(input int nbits);
        int len;
        int mism = 0;
        logic [7:0] rb [0:17];
        logic [15:0] recv;
        len = exp_len[fcount];
        chk(nbits % 8 == 0 && nbits / 8 == len + 2, "R4 frame bit count", nbits, (len + 2) * 8);
        if (nbits == (len + 2) * 8) begin
            for (int k = 0; k < len + 2; k++)
                for (int i = 0; i < 8; i++) rb[k][i] = dec_bits[8*k + i];
            for (int k = 0; k < len; k++) if (rb[k] !== exp_data[fcount][k]) mism++;
            chk(mism == 0, "R4,R5 payload bytes", mism, 0);
            recv = {rb[len + 1], rb[len]};
            chk(recv == ref_fcs(fcount, len), "R6 check bytes", recv, ref_fcs(fcount, len));
            if (fcount == 0) chk(recv == 16'h906E, "R6 known vector", recv, 16'h906E);
        end
        fcount++;
    endtask

    task automatic decode(input logic b);
        int prev_run;
        if (raw_cnt < 24) raw_idle[raw_cnt] = b;
        raw_cnt++;
        prev_run = dec_run;
        dec_last8 = {dec_last8[6:0], b};
        dec_run = b ? dec_run + 1 : 0;
        if (dec_last8 == 8'h7E) begin
            if (!dec_hunt && dec_nb - 7 > 0) end_frame(dec_nb - 7);
            dec_hunt = 0;
            dec_nb = 0;
        end else if (dec_run >= 7) begin
            if (!dec_hunt) abort_cnt++;
            dec_hunt = 1;
            dec_nb = 0;
        end else if (!dec_hunt) begin
            if (!(b == 1'b0 && prev_run == 5) && dec_nb < 1024) begin
                dec_bits[dec_nb] = b;
                dec_nb++;
            end
        end
    endtask

    logic rst_seen = 1;
    always @(posedge clk) rst_seen <= rst;

    int cyc = 0, hold_chk = 0;
    logic prev_line = 1;
    always @(negedge clk) begin
        if (!rst_seen && bit_en) decode(line_bit);
        if (!rst_seen && !bit_en && hold_chk < 16) begin
            hold_chk++;
            chk(line_bit == prev_line, "R3 line holds without enable", line_bit, prev_line);
        end
        prev_line = line_bit;
        if (fire_pending) q_i++;
        cyc++;
        bit_en = (cyc % 3) != 2;
        in_valid = !rst && (q_i < q_n);
        in_data  = q_data[q_i % 256];
        in_last  = q_last[q_i % 256];
        #1;
        fire_pending = in_valid && in_ready;
        if (in_ready && !bit_en) ready_viol++;
    end

    always @(posedge clk) if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        finish_run();
    end

    task automatic timeout(input string what);
        chk(0, what, 0, 1);
        finish_run();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #2;
        chk(line_bit == 1'b1, "R1 line mark in reset", line_bit, 1);
        chk(in_ready == 1'b0, "R1 ready low in reset", in_ready, 0);
        @(negedge clk);
        rst = 0;

        for (int t = 0; t < 2000 && raw_cnt < 24; t++) @(negedge clk);
        if (raw_cnt < 24) timeout("R2 idle bits timeout");
        begin
            int bad = 0;
            for (int i = 0; i < 24; i++)
                if (raw_idle[i] !== ((i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1)) bad++;
            chk(bad == 0, "R1,R2 idle flags", bad, 0);
        end

        for (int f = 0; f < NTBL; f++) push_frame(TBL_BYTES[f], TBL_LEN[f], 1);
        for (int t = 0; t < 20000 && fcount < NTBL; t++) @(negedge clk);
        if (fcount < NTBL) timeout("R4 table frames timeout");
        chk(abort_cnt == 0, "R4 no abort on full frames", abort_cnt, 0);

        push_frame(96'h22_11, 2, 0);
        for (int t = 0; t < 5000 && abort_cnt < 1; t++) @(negedge clk);
        chk(abort_cnt == 1, "R8 abort on underrun", abort_cnt, 1);
        chk(fcount == NTBL, "R8 no frame from aborted data", fcount, NTBL);

        push_frame(96'hC3_7E_FF, 3, 1);
        for (int t = 0; t < 5000 && fcount < NTBL + 1; t++) @(negedge clk);
        chk(fcount == NTBL + 1, "R8 frame after abort", fcount, NTBL + 1);

        repeat (40) @(negedge clk);
        chk(ready_viol == 0, "R7 ready only with enable", ready_viol, 0);
        chk(q_i == q_n, "R7 all bytes taken", q_i, q_n);
        finish_run();
    end
endmodule